// File: doc/BRIEF.md
# Wait-State Memory Slave

A small clocked RAM that sits behind a single-word bus and answers every access with a status code. A caller presents an access by holding the valid, direction, address and (for writes) data inputs. The slave answers WAIT for a programmable number of cycles and then OK, and the caller keeps presenting the same access until OK appears. A down-counter holds the remaining wait states. It is loaded on the first cycle of a new access and counts toward zero once per clock.

The slave decodes a fixed window of addresses and publishes the lowest and highest address of that window, so a bus decoder can route requests to it. An access outside the window is refused with ERROR at once and touches nothing. Write data is committed only in the OK cycle. Read data is driven only in the OK cycle and is zero otherwise. A wait count of zero turns the slave into a single-cycle memory.

Top module: `wait_mem_slave`

## Requirements
- R1: During and after synchronous reset, the status output reads IDLE (code 2'b00) while no access is presented, every array word reads back as zero, and any access held before reset is forgotten.
- R2: `win_lo` equals the BASE parameter, and `win_hi` equals BASE + 2**IDX_W - 1.
- R3: An access with an address below `win_lo` or above `win_hi` returns ERROR (2'b11) in the same cycle, inserts no wait state and leaves the array unchanged.
- R4: With a wait count N >= 1, an in-window access returns WAIT (2'b01) for exactly N consecutive cycles, then OK (2'b10) on the next cycle.
- R5: With a wait count of zero, an in-window access returns OK in the cycle it is first presented.
- R6: A write stores its data only in its OK cycle. A read drives the stored word on `resp_rdata` in its OK cycle, and `resp_rdata` is zero in every cycle whose status is not OK.
- R7: A new access starts and reloads the counter from `wait_cfg` whenever the address or direction differs from the held access, or when no access was held.
- R8: When `acc_valid` is low, the status is IDLE and any held access is dropped. A write dropped this way never reaches the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Word address |
| acc_wdata | input | DATA_W | Write data |
| wait_cfg | input | CNT_W | Wait states inserted per access |
| resp_status | output | 2 | 00 IDLE, 01 WAIT, 10 OK, 11 ERROR |
| resp_rdata | output | DATA_W | Read data, valid with OK |
| win_lo | output | ADDR_W | First address of the window |
| win_hi | output | ADDR_W | Last address of the window |

## Verification
The stimulus exercises wait counts of zero, one, two and three, so that an off-by-one in the counter load shows up as a wrong number of WAIT cycles. Accesses land on both window edges and just outside them, including an address that aliases index zero when only the low bits are kept, which separates a full range check from a truncated one. Some accesses change address partway through, and one write is abandoned partway through. Reading both words back afterwards tells a restart from a continuation and a late commit from a missed one. Reads at zero wait confirm that data appears only alongside OK.

// File: rtl/wsm_pkg.sv
package wsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_OK   = 2'b10,
        ST_ERR  = 2'b11
    } st_t;

    typedef struct packed {
        logic busy;
        logic write;
    } hold_flags_t;

endpackage

// File: rtl/wsm_window.sv
module wsm_window #(
    parameter int                ADDR_W = 8,
    parameter int                IDX_W  = 4,
    parameter logic [ADDR_W-1:0] BASE   = 8'h20
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi
);
    localparam int                DEPTH = 1 << IDX_W;
    localparam logic [ADDR_W-1:0] LAST  = ADDR_W'(BASE + DEPTH - 1);

    logic [ADDR_W-1:0] off;

    always_comb begin
        off    = addr - BASE;
        in_win = (addr >= BASE) && (addr <= LAST);
        idx    = off[IDX_W-1:0];
        lo     = BASE;
        hi     = LAST;
    end
endmodule

// File: rtl/wsm_counter.sv
module wsm_counter
    import wsm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic              in_win,
    input  logic [CNT_W-1:0]  cfg,
    output st_t               status,
    output logic              fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    hold_flags_t       hold_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              is_new;

    always_comb begin
        is_new = !hold_q.busy || (addr != addr_q) || (write != hold_q.write);
        status = ST_IDLE;
        fire   = 1'b0;
        if (valid) begin
            if (!in_win) begin
                status = ST_ERR;
            end else if (is_new) begin
                if (cfg == '0) begin
                    status = ST_OK;
                    fire   = 1'b1;
                end else begin
                    status = ST_WAIT;
                end
            end else if (cnt_q == '0) begin
                status = ST_OK;
                fire   = 1'b1;
            end else begin
                status = ST_WAIT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (!valid || !in_win) begin
            hold_q.busy <= 1'b0;
        end else if (is_new) begin
            hold_q.busy  <= (cfg != '0);
            hold_q.write <= write;
            addr_q       <= addr;
            cnt_q        <= (cfg != '0) ? cfg - ONE : '0;
        end else if (cnt_q == '0) begin
            hold_q.busy <= 1'b0;
        end else begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // R4: a held, unfinished access counts down by exactly one per cycle
    p_countdown_r4: assert property (@(posedge clk) disable iff (rst)
        (valid && in_win && !is_new && cnt_q != '0)
        |=> (hold_q.busy && cnt_q == $past(cnt_q) - ONE));

    // R5: zero wait count gives immediate completion
    p_zero_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (valid && in_win && is_new && cfg == '0) |-> fire);

    // R7: a fresh access with nonzero wait never completes in its first cycle
    p_fresh_waits_r7: assert property (@(posedge clk) disable iff (rst)
        (valid && in_win && is_new && cfg != '0) |-> (status == ST_WAIT));
endmodule

// File: rtl/wsm_array.sv
module wsm_array #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[idx] <= wdata;
        end
    end

    always_comb rdata = re ? mem_q[idx] : '0;

    // R6: a read strobe and a write strobe never coincide
    p_strobes_apart_r6: assert property (@(posedge clk) disable iff (rst)
        !(we && re));
endmodule

// File: rtl/wait_mem_slave.sv
module wait_mem_slave
    import wsm_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter int                DATA_W = 16,
    parameter int                IDX_W  = 4,
    parameter int                CNT_W  = 4,
    parameter logic [ADDR_W-1:0] BASE   = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [CNT_W-1:0]  wait_cfg,
    output logic [1:0]        resp_status,
    output logic [DATA_W-1:0] resp_rdata,
    output logic [ADDR_W-1:0] win_lo,
    output logic [ADDR_W-1:0] win_hi
);
    logic             in_win;
    logic [IDX_W-1:0] idx;
    logic             fire;
    st_t              status;

    wsm_window #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_win (
        .addr(acc_addr), .in_win(in_win), .idx(idx), .lo(win_lo), .hi(win_hi)
    );

    wsm_counter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .valid(acc_valid), .write(acc_write),
        .addr(acc_addr), .in_win(in_win), .cfg(wait_cfg),
        .status(status), .fire(fire)
    );

    wsm_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_arr (
        .clk(clk), .rst(rst), .we(fire && acc_write), .re(fire && !acc_write),
        .idx(idx), .wdata(acc_wdata), .rdata(resp_rdata)
    );

    assign resp_status = status;

    // R3: outside the published window the answer is always ERROR
    p_outside_err_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (acc_addr < win_lo || acc_addr > win_hi))
        |-> (resp_status == 2'b11));

    // R6: read data is quiet unless the status is OK
    p_rdata_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (resp_status != 2'b10) |-> (resp_rdata == '0));

    // R8: no access presented means IDLE
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (resp_status == 2'b00));
endmodule

// File: tb/sim_wait_mem_slave.sv
module sim_wait_mem_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [3:0]  wait_cfg = '0;
    logic [1:0]  resp_status;
    logic [15:0] resp_rdata;
    logic [7:0]  win_lo;
    logic [7:0]  win_hi;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wait_mem_slave u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .wait_cfg(wait_cfg),
        .resp_status(resp_status), .resp_rdata(resp_rdata),
        .win_lo(win_lo), .win_hi(win_hi)
    );

    localparam logic [1:0] I = 2'd0, W = 2'd1, K = 2'd2, E = 2'd3;

    // {valid, write, addr, wdata, cfg, expected status, expected rdata}
    localparam int NV = 29;
    localparam logic [47:0] TBL [NV] = '{
        {1'b1, 1'b1, 8'h21, 16'hAAAA, 4'd0, K, 16'h0000}, // R5 write
        {1'b1, 1'b0, 8'h21, 16'h0000, 4'd0, K, 16'hAAAA}, // R5 R6 read
        {1'b1, 1'b1, 8'h22, 16'h1234, 4'd2, W, 16'h0000}, // R4
        {1'b1, 1'b1, 8'h22, 16'h1234, 4'd2, W, 16'h0000},
        {1'b1, 1'b1, 8'h22, 16'h1234, 4'd2, K, 16'h0000},
        {1'b1, 1'b0, 8'h22, 16'h0000, 4'd2, W, 16'h0000}, // R7 direction
        {1'b1, 1'b0, 8'h22, 16'h0000, 4'd2, W, 16'h0000},
        {1'b1, 1'b0, 8'h22, 16'h0000, 4'd2, K, 16'h1234},
        {1'b1, 1'b0, 8'h40, 16'h0000, 4'd2, E, 16'h0000}, // R3 above
        {1'b1, 1'b1, 8'h1F, 16'h5555, 4'd0, E, 16'h0000}, // R3 below
        {1'b1, 1'b1, 8'h2F, 16'hBEEF, 4'd1, W, 16'h0000}, // R4 top edge
        {1'b1, 1'b1, 8'h2F, 16'hBEEF, 4'd1, K, 16'h0000},
        {1'b1, 1'b0, 8'h2F, 16'h0000, 4'd0, K, 16'hBEEF},
        {1'b0, 1'b0, 8'h2F, 16'h0000, 4'd0, I, 16'h0000}, // R8
        {1'b1, 1'b1, 8'h23, 16'h7777, 4'd3, W, 16'h0000}, // R7 restart
        {1'b1, 1'b1, 8'h23, 16'h7777, 4'd3, W, 16'h0000},
        {1'b1, 1'b1, 8'h24, 16'h7777, 4'd3, W, 16'h0000},
        {1'b1, 1'b1, 8'h24, 16'h7777, 4'd3, W, 16'h0000},
        {1'b1, 1'b1, 8'h24, 16'h7777, 4'd3, W, 16'h0000},
        {1'b1, 1'b1, 8'h24, 16'h7777, 4'd3, K, 16'h0000},
        {1'b1, 1'b1, 8'h25, 16'h9999, 4'd2, W, 16'h0000}, // R8 abandon
        {1'b0, 1'b1, 8'h25, 16'h9999, 4'd2, I, 16'h0000},
        {1'b1, 1'b0, 8'h25, 16'h0000, 4'd0, K, 16'h0000}, // R8 not written
        {1'b1, 1'b0, 8'h24, 16'h0000, 4'd0, K, 16'h7777},
        {1'b1, 1'b0, 8'h23, 16'h0000, 4'd0, K, 16'h0000}, // R7 no commit
        {1'b1, 1'b0, 8'h2F, 16'h0000, 4'd1, W, 16'h0000},
        {1'b1, 1'b0, 8'h2F, 16'h0000, 4'd1, K, 16'hBEEF},
        {1'b1, 1'b1, 8'h30, 16'h3333, 4'd0, E, 16'h0000}, // R3 alias
        {1'b1, 1'b0, 8'h20, 16'h0000, 4'd0, K, 16'h0000}  // R3 R1 idx 0
    };

    task automatic check(input string req, input logic [1:0] exp_st,
                         input logic [15:0] exp_rd);
        n_chk++;
        if (resp_status !== exp_st || resp_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s: status=%0d rdata=%h expected status=%0d rdata=%h",
                     req, resp_status, resp_rdata, exp_st, exp_rd);
        end
    endtask

    task automatic drive(input logic v, input logic wr, input logic [7:0] a,
                         input logic [15:0] d, input logic [3:0] c);
        @(negedge clk);
        acc_valid = v; acc_write = wr; acc_addr = a; acc_wdata = d; wait_cfg = c;
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 reset idle", I, 16'h0000);
        rst = 1'b0;

        // R2: window bounds
        n_chk++;
        if (win_lo !== 8'h20 || win_hi !== 8'h2F) begin
            n_fail++;
            $display("FAIL R2: lo=%h hi=%h expected lo=20 hi=2f", win_lo, win_hi);
        end

        for (int k = 0; k < NV; k++) begin
            drive(TBL[k][47], TBL[k][46], TBL[k][45:38], TBL[k][37:22], TBL[k][21:18]);
            check($sformatf("R4 R5 R6 table row %0d", k), TBL[k][17:16], TBL[k][15:0]);
        end

        // R1: reset in the middle of a wait sequence forgets the held access
        drive(1'b1, 1'b0, 8'h21, 16'h0, 4'd3);
        check("R1 pre-reset wait", W, 16'h0000);
        @(negedge clk); rst = 1'b1; acc_valid = 1'b0;
        @(negedge clk); rst = 1'b0;
        drive(1'b1, 1'b0, 8'h21, 16'h0, 4'd1);
        check("R1 restart after reset", W, 16'h0000);
        drive(1'b1, 1'b0, 8'h21, 16'h0, 4'd1);
        check("R1 cleared array", K, 16'h0000);

        // R4: re-presenting after OK starts a fresh access
        drive(1'b1, 1'b0, 8'h21, 16'h0, 4'd1);
        check("R4 fresh after OK", W, 16'h0000);
        drive(1'b0, 1'b0, 8'h21, 16'h0, 4'd0);
        check("R8 idle", I, 16'h0000);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule